// File: doc/BRIEF.md
# Read strobe sampling monitor

This block takes one measurement of the read data strobe at whatever receive-enable delay the surrounding logic has set. A single start pulse begins a run. The block first wipes the status left by the previous run. It then issues a fixed burst of read transactions, one at a time, to a memory-read request port. During each run it collapses every strobe level it captured into a two-bit verdict: the strobe was high on every read, low on every read, or a mix of both.

The probe address depends on which channel is measured and on how the channels share the address space. When the channels are interleaved, the second channel is reached through a low address bit. When they are not, it is reached through a high address formed from the rank-boundary byte. Each burst step reads a base address and then a second address a fixed stride above it. Calibration firmware or a training sequencer calls the block over and over while it steps the delay setting, and uses the verdict to find the strobe preamble and its edges.

Top module: `strobe_probe`

## Requirements
- R1: After reset, `rd_req_o`, `done_o` and `busy_o` are 0 and `result_o` is 2'b00.
- R2: While idle, a high `start_i` is accepted and latches `chan_sel_i`, `interleave_i` and `boundary_i` for the whole run. The cycle after acceptance is a clear cycle. In that cycle `busy_o` is 1, `rd_req_o` is 0, and the accumulated status is reset.
- R3: A run issues exactly 2*ITERATIONS reads (56 by default). Read k (counting from 0) uses the base address when k is even and the base address plus PAIR_STRIDE (0x80) when k is odd.
- R4: With `chan_sel_i` = 0 the base address is 0.
- R5: With `chan_sel_i` = 1 and `interleave_i` = 1 the base address has only bit ILV_BIT (bit 6, value 0x40) set.
- R6: With `chan_sel_i` = 1 and `interleave_i` = 0 the base address is `boundary_i` shifted left by BOUND_SHIFT (25), truncated to ADDR_W (32) bits. At the defaults this drops bit 7 of the byte.
- R7: Only one read is outstanding at a time. `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i` is seen, and the address moves to the next read only after that. `strobe_i` is captured only in a cycle where `rd_req_o` and `rd_ack_i` are both high.
- R8: `result_o` bit 1 set means every captured sample was high, and bit 0 set means every sample was low. 2'b00 means the samples were mixed.
- R9: `done_o` is high for exactly one cycle: the cycle after the edge that captures the last acknowledge. `busy_o` is high from the clear cycle through the `done_o` cycle and low in the cycle after it.
- R10: A `start_i` that arrives while `busy_o` is high, including the `done_o` cycle, is ignored. It does not restart the run or alter the address sequence, and it does not start a new run.
- R11: Outside a run, `result_o` keeps the verdict of the last run, and `rd_ack_i` has no effect on it, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one sampling run (accepted only while idle) |
| chan_sel_i | input | 1 | Channel to probe: 0 or 1 |
| interleave_i | input | 1 | Channels are address-interleaved |
| boundary_i | input | 8 | Rank-boundary byte used to form the second channel's address when not interleaved |
| rd_req_o | output | 1 | Read request to memory |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; the strobe is captured in this cycle |
| strobe_i | input | 1 | Sampled strobe level for the acknowledged read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when `result_o` holds the new verdict |
| result_o | output | 2 | Verdict: bit 1 = all high, bit 0 = all low, 00 = mixed |

## Verification
Two things can land in the same cycle: a new start request and an acknowledge of an ongoing read, or a new start request and the done pulse. The bench raises `start_i` together with the acknowledge of a mid-burst read, while it also changes the channel, interleave and boundary inputs. It also raises `start_i` in the exact cycle where `done_o` is high. It then checks that the remaining addresses still follow the first configuration, that `busy_o` falls right after the single done pulse, and that no second run begins. Sweeps over every boundary byte and every position of a single differing strobe sample cover the address and verdict arithmetic.

// File: rtl/strobe_probe_pkg.sv
package strobe_probe_pkg;

    // Run phases of the sampling sequencer
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_READ  = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;

    // Configuration captured at the accepted start
    localparam int unsigned BOUND_W = 8;

    typedef struct packed {
        logic               chan;
        logic               ilv;
        logic [BOUND_W-1:0] bound;
    } probe_cfg_t;

    // Running strobe status
    typedef struct packed {
        logic all_high;
        logic all_low;
    } level_acc_t;

    // Fold one captured sample into the running status
    function automatic level_acc_t fold_sample(level_acc_t acc, logic level);
        level_acc_t nxt;
        nxt.all_high = acc.all_high & level;
        nxt.all_low  = acc.all_low & ~level;
        return nxt;
    endfunction

    // Status right after the clear cycle (no sample seen yet)
    localparam level_acc_t ACC_CLEARED = '{all_high: 1'b1, all_low: 1'b1};
    localparam level_acc_t ACC_RESET   = '{all_high: 1'b0, all_low: 1'b0};

endpackage

// File: rtl/strobe_probe_seq.sv
module strobe_probe_seq
    import strobe_probe_pkg::*;
#(
    parameter int unsigned READS = 56
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic                         ack_i,
    output phase_t                       phase_o,
    output logic                         accept_o,
    output logic [$clog2(READS)-1:0]     idx_o
);
    localparam int unsigned IDX_W = $clog2(READS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(READS - 1);

    phase_t           phase_q;
    logic [IDX_W-1:0] idx_q;

    assign accept_o = (phase_q == PH_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_CLEAR;
                        idx_q   <= '0;
                    end
                end
                PH_CLEAR: phase_q <= PH_READ;
                PH_READ: begin
                    if (ack_i) begin
                        if (idx_q == LAST_IDX) begin
                            phase_q <= PH_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/strobe_probe_addr.sv
module strobe_probe_addr
    import strobe_probe_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ILV_BIT     = 6,
    parameter int unsigned BOUND_SHIFT = 25,
    parameter int unsigned PAIR_STRIDE = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  probe_cfg_t        cfg_i,
    input  logic              odd_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(PAIR_STRIDE);
    localparam logic [ADDR_W-1:0] ILV_V    = ADDR_W'(1) << ILV_BIT;

    logic [ADDR_W-1:0] base_next;
    logic [ADDR_W-1:0] base_q;

    // Probe base address selected by channel and interleave mode
    always_comb begin
        if (!cfg_i.chan) begin
            base_next = '0;
        end else if (cfg_i.ilv) begin
            base_next = ILV_V;
        end else begin
            base_next = ADDR_W'(cfg_i.bound) << BOUND_SHIFT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (load_i) begin
            base_q <= base_next;
        end
    end

    assign addr_o = base_q + (odd_i ? STRIDE_V : '0);

endmodule

// File: rtl/strobe_probe_acc.sv
module strobe_probe_acc
    import strobe_probe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_i,
    input  logic       capture_i,
    input  logic       level_i,
    output logic [1:0] code_o
);
    level_acc_t acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= ACC_RESET;
        end else if (clear_i) begin
            acc_q <= ACC_CLEARED;
        end else if (capture_i) begin
            acc_q <= fold_sample(acc_q, level_i);
        end
    end

    assign code_o = {acc_q.all_high, acc_q.all_low};

endmodule

// File: rtl/strobe_probe.sv
module strobe_probe
    import strobe_probe_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ITERATIONS  = 28,
    parameter int unsigned PAIR_STRIDE = 128,
    parameter int unsigned ILV_BIT     = 6,
    parameter int unsigned BOUND_SHIFT = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              chan_sel_i,
    input  logic              interleave_i,
    input  logic [7:0]        boundary_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic              strobe_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o
);
    localparam int unsigned READS = 2 * ITERATIONS;
    localparam int unsigned IDX_W = $clog2(READS);

    phase_t           phase;
    logic             accept;
    logic [IDX_W-1:0] idx;
    logic             capture;
    probe_cfg_t       cfg;

    assign cfg = '{chan: chan_sel_i, ilv: interleave_i, bound: boundary_i};

    strobe_probe_seq #(
        .READS(READS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ack_i   (rd_ack_i),
        .phase_o (phase),
        .accept_o(accept),
        .idx_o   (idx)
    );

    strobe_probe_addr #(
        .ADDR_W     (ADDR_W),
        .ILV_BIT    (ILV_BIT),
        .BOUND_SHIFT(BOUND_SHIFT),
        .PAIR_STRIDE(PAIR_STRIDE)
    ) u_addr (
        .clk   (clk),
        .rst   (rst),
        .load_i(accept),
        .cfg_i (cfg),
        .odd_i (idx[0]),
        .addr_o(rd_addr_o)
    );

    assign capture = (phase == PH_READ) && rd_ack_i;

    strobe_probe_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (phase == PH_CLEAR),
        .capture_i(capture),
        .level_i  (strobe_i),
        .code_o   (result_o)
    );

    assign rd_req_o = (phase == PH_READ);
    assign busy_o   = (phase != PH_IDLE);
    assign done_o   = (phase == PH_DONE);

endmodule

// File: rtl/strobe_probe_chk.sv
module strobe_probe_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned READS  = 56
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        result_o
);
    localparam int unsigned CW = $clog2(READS + 1);

    logic [CW-1:0] ack_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_cnt <= '0;
        end else if (start_i && !busy_o) begin
            ack_cnt <= '0;
        end else if (rd_req_o && rd_ack_i) begin
            ack_cnt <= ack_cnt + 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!rd_req_o && !done_o));

    assert_clear_first_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !rd_req_o));

    assert_read_count_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ack_cnt == CW'(READS)));

    assert_hold_request_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o != 2'b11));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    assert_busy_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(result_o));

endmodule

bind strobe_probe strobe_probe_chk #(
    .ADDR_W(ADDR_W),
    .READS (READS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .rd_ack_i (rd_ack_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/strobe_probe_test.sv
module strobe_probe_test;
    localparam int CLK_PERIOD = 10;
    localparam int ITER       = 28;
    localparam int READS      = 2 * ITER;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              chan_sel_i = 1'b0;
    logic              interleave_i = 1'b0;
    logic [7:0]        boundary_i = 8'h00;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic              strobe_i = 1'b0;
    logic              busy_o;
    logic              done_o;
    logic [1:0]        result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    strobe_probe uut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .chan_sel_i  (chan_sel_i),
        .interleave_i(interleave_i),
        .boundary_i  (boundary_i),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .rd_ack_i    (rd_ack_i),
        .strobe_i    (strobe_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One complete run: drives start, answers every read, judges address and verdict.
    // poke_k in [0, READS-1] raises start with the ack of read poke_k; poke_k == READS
    // raises start in the done cycle; -1 means no extra start.
    task automatic run_probe(input logic chan, input logic ilv, input logic [7:0] bnd,
                             input logic [READS-1:0] pat, input int dly, input int poke_k);
        logic [31:0] base;
        logic [31:0] ea;
        logic [1:0]  ecode;
        string       tag;
        if (!chan) begin
            base = 32'd0;
            tag  = "R4";
        end else if (ilv) begin
            base = 32'd64;
            tag  = "R5";
        end else begin
            base = 32'(bnd) * 32'd33554432;
            tag  = "R6";
        end
        ecode = {&pat, ~|pat};

        @(negedge clk);
        chan_sel_i   = chan;
        interleave_i = ilv;
        boundary_i   = bnd;
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
        // R2: clear cycle, and config now changed to prove it was latched
        check(busy_o && !rd_req_o, "R2", "clear cycle busy/req", {busy_o, rd_req_o}, 2'b10);
        chan_sel_i   = ~chan;
        interleave_i = ~ilv;
        boundary_i   = ~bnd;
        @(negedge clk);
        for (int k = 0; k < READS; k++) begin
            ea = base + ((k % 2 == 1) ? 32'd128 : 32'd0);
            start_i = 1'b0;
            if (dly > 0) begin
                rd_ack_i = 1'b0;
                for (int w = 0; w < dly; w++) begin
                    strobe_i = ~pat[k];
                    check(rd_req_o && rd_addr_o == ea, "R7", "request held while waiting",
                          {rd_req_o, rd_addr_o}, {1'b1, ea});
                    @(negedge clk);
                end
            end
            check(rd_req_o && rd_addr_o == ea, (k % 2 == 1) ? "R3" : tag, "read address",
                  {rd_req_o, rd_addr_o}, {1'b1, ea});
            if (k == poke_k) start_i = 1'b1;
            rd_ack_i = 1'b1;
            strobe_i = pat[k];
            @(negedge clk);
        end
        rd_ack_i = 1'b0;
        start_i  = 1'b0;
        check(done_o && busy_o && !rd_req_o, "R9", "done cycle", {done_o, busy_o, rd_req_o}, 3'b110);
        check(result_o == ecode, "R8", "verdict", result_o, ecode);
        if (poke_k == READS) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o && !busy_o, "R10", "idle after done, late start ignored",
              {done_o, busy_o}, 2'b00);
        // R11: acks outside a run have no effect on the held verdict
        rd_ack_i = 1'b1;
        strobe_i = ~strobe_i;
        repeat (2) @(negedge clk);
        rd_ack_i = 1'b0;
        check(result_o == ecode && !rd_req_o && !busy_o, "R11", "verdict held while idle",
              {result_o, rd_req_o, busy_o}, {ecode, 2'b00});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [READS-1:0] p;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rd_req_o && !done_o && !busy_o && result_o == 2'b00, "R1", "reset state",
              {rd_req_o, done_o, busy_o, result_o}, 5'b0);
        rst = 1'b0;
        @(negedge clk);
        check(!rd_req_o && !done_o && !busy_o && result_o == 2'b00, "R1", "idle after reset",
              {rd_req_o, done_o, busy_o, result_o}, 5'b0);

        // Directed runs
        run_probe(1'b0, 1'b0, 8'h5a, {READS{1'b1}}, 0, -1);
        run_probe(1'b0, 1'b1, 8'h33, {READS{1'b0}}, 1, -1);
        p = '0;
        for (int i = 0; i < READS; i += 3) p[i] = 1'b1;
        run_probe(1'b1, 1'b1, 8'hff, p, 2, -1);
        run_probe(1'b1, 1'b0, 8'ha5, {READS{1'b1}}, 0, -1);
        // R2: low after high proves the clear
        run_probe(1'b1, 1'b0, 8'h81, {READS{1'b0}}, 0, -1);

        // R10: start with a mid-burst ack, and start in the done cycle
        run_probe(1'b1, 1'b0, 8'h12, {READS{1'b1}}, 0, 10);
        run_probe(1'b0, 1'b0, 8'h00, {READS{1'b0}}, 1, 31);
        run_probe(1'b1, 1'b1, 8'h44, {READS{1'b1}}, 0, READS);

        // R6: every boundary byte
        for (int b = 0; b < 256; b++) begin
            run_probe(1'b1, 1'b0, 8'(b), (b % 2 == 0) ? {READS{1'b1}} : {READS{1'b0}}, 0, -1);
        end

        // R8: every position of a single differing sample in both polarities
        for (int pos = 0; pos < READS; pos++) begin
            p = {READS{1'b1}};
            p[pos] = 1'b0;
            run_probe(1'(pos % 2), 1'(pos % 3 == 0), 8'(pos), p, 0, -1);
            p = '0;
            p[pos] = 1'b1;
            run_probe(1'(pos % 2 == 0), 1'b0, 8'(pos + 100), p, pos % 2, -1);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule